// File: doc/BRIEF.md
# Versioned Lock-Table Read Validator

This block is the hardware core of a global-version-clock concurrency scheme for optimistic transactions. It keeps a single global version counter and a table of entries. Each entry pairs a lock flag with a version stamp, and the table is indexed by a hash of the word address. A transaction records the counter as its start stamp when it begins. Each of its reads is then checked against the entry for that word. A read is accepted only if the entry is unlocked and was last stamped no later than the transaction began.

Writers take entry locks through the lock port. When an update transaction commits, the counter advances by one. In the same cycle, every word the transaction wrote is stamped with the new counter value and its lock is dropped. Read-only transactions commit without touching the counter or the table. The data memory, write-set forwarding and revalidation are handled outside this block.

Top module: `vlock_validator`

## Requirements
- R1: After reset the global counter is 0, every entry is unlocked with stamp 0, every start stamp is 0, and both response valids are low.
- R2: The counter `gclk` rises by exactly one in the cycle after a commit with `cm_valid=1` and `cm_update=1`. A commit with `cm_update=0` (read-only) leaves it unchanged.
- R3: `start_valid` stores the counter value of that cycle in slot `start_tx`. If an update commit happens in the same cycle, the stored value is the one from before the increment.
- R4: A read check gives `rd_resp_valid=1` one cycle later. It gives `rd_ok=1` only when the entry's lock is clear and its stamp is less than or equal to the start stamp of slot `rd_tx`.
- R5: A read check issued in the same cycle as an update commit sees the entry lock and stamp from before that commit.
- R6: An update commit writes the new counter value into the stamp of every entry selected by a set bit of `cm_wr_en`, and clears that entry's lock. This holds even if the entry was locked, and it takes priority over a lock request to the same entry in that cycle.
- R7: `lk_acquire=1` on an unlocked entry sets its lock and answers `lk_busy=0` one cycle later. On an already locked entry it answers `lk_busy=1` and leaves the entry unchanged.
- R8: `lk_acquire=0` (release) clears the entry's lock, leaves its stamp unchanged, and answers `lk_busy=0`.
- R9: The table index is the low log2(DEPTH) bits of the word address. Addresses that share those bits share one entry.
- R10: The write enables of a read-only commit are ignored: no stamp or lock changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_valid | input | 1 | Record a start stamp |
| start_tx | input | TXW | Slot receiving the start stamp |
| rd_valid | input | 1 | Read check request |
| rd_tx | input | TXW | Slot whose start stamp is used |
| rd_addr | input | AW | Word address being read |
| rd_resp_valid | output | 1 | Read check result valid |
| rd_ok | output | 1 | Read is consistent |
| lk_valid | input | 1 | Lock or release request |
| lk_acquire | input | 1 | 1 = lock, 0 = release |
| lk_addr | input | AW | Word address to lock or release |
| lk_resp_valid | output | 1 | Lock result valid |
| lk_busy | output | 1 | Lock refused, entry already held |
| cm_valid | input | 1 | Commit request |
| cm_update | input | 1 | 1 = update transaction, 0 = read-only |
| cm_wr_en | input | NWR | Per-port write-address enables |
| cm_wr_addr | input | NWR*AW | Packed written word addresses, port k at bits k*AW |
| gclk | output | TSW | Global version counter |

## Verification
The bench builds the block with DEPTH=16, AW=16, TSW=8, NWR=2 and NUM_TX=4. The 16-entry table makes address aliasing easy to reach: addresses 16 apart fall on the same entry. Two commit ports make a two-word stamp in one cycle possible. Four slots let start stamps taken before and after commits be compared side by side. The scenarios also cover the same-cycle cases: a read against a commit, a start against a commit, and a lock against a commit stamp.

// File: rtl/vlock_pkg.sv
package vlock_pkg;
   typedef enum logic {
      LK_RELEASE = 1'b0,
      LK_ACQUIRE = 1'b1
   } lk_op_t;

   function automatic int idx_bits(input int depth);
      return (depth > 1) ? $clog2(depth) : 1;
   endfunction
endpackage

// File: rtl/vlock_clock.sv
module vlock_clock #(
   parameter int TSW = 16
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           bump,
   output logic [TSW-1:0] gclk_q,
   output logic [TSW-1:0] gclk_next
);
   assign gclk_next = gclk_q + TSW'(1);

   always_ff @(posedge clk) begin
      if (!rst_n)    gclk_q <= '0;
      else if (bump) gclk_q <= gclk_next;
   end
endmodule

// File: rtl/vlock_start.sv
module vlock_start #(
   parameter int TSW    = 16,
   parameter int NUM_TX = 4,
   localparam int TXW   = (NUM_TX > 1) ? $clog2(NUM_TX) : 1
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           st_valid,
   input  logic [TXW-1:0] st_tx,
   input  logic [TSW-1:0] gclk,
   input  logic [TXW-1:0] rd_tx,
   output logic [TSW-1:0] rd_start
);
   logic [NUM_TX*TSW-1:0] slots;

   for (genvar t = 0; t < NUM_TX; t++) begin : g_slot
      logic [TSW-1:0] q;
      always_ff @(posedge clk) begin
         if (!rst_n)                              q <= '0;
         else if (st_valid && st_tx == TXW'(t))   q <= gclk;
      end
      assign slots[t*TSW +: TSW] = q;
   end

   assign rd_start = slots[rd_tx*TSW +: TSW];
endmodule

// File: rtl/vlock_table.sv
module vlock_table #(
   parameter int DEPTH = 256,
   parameter int TSW   = 16,
   parameter int NWR   = 2,
   localparam int IW   = $clog2(DEPTH)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [IW-1:0]   rd_idx,
   output logic            rd_locked,
   output logic [TSW-1:0]  rd_ts,
   input  logic            lk_valid,
   input  logic            lk_acquire,
   input  logic [IW-1:0]   lk_idx,
   output logic            lk_locked,
   input  logic [NWR-1:0]  st_en,
   input  logic [NWR*IW-1:0] st_idx,
   input  logic [TSW-1:0]  st_ts
);
   import vlock_pkg::*;

   logic [DEPTH-1:0] lock_q;
   logic [TSW-1:0]   ts_q [DEPTH];
   logic [DEPTH-1:0] st_hit;
   logic [DEPTH-1:0] lk_hit;
   lk_op_t           lk_op;

   assign lk_op = lk_op_t'(lk_acquire);

   for (genvar e = 0; e < DEPTH; e++) begin : g_ent
      logic hit;
      always_comb begin
         hit = 1'b0;
         for (int k = 0; k < NWR; k++) begin
            if (st_en[k] && st_idx[k*IW +: IW] == IW'(e)) hit = 1'b1;
         end
      end
      assign st_hit[e] = hit;
      assign lk_hit[e] = lk_valid && (lk_idx == IW'(e)) &&
                         !(lk_op == LK_ACQUIRE && lock_q[e]);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         lock_q <= '0;
         for (int e = 0; e < DEPTH; e++) ts_q[e] <= '0;
      end else begin
         for (int e = 0; e < DEPTH; e++) begin
            if (st_hit[e]) begin
               lock_q[e] <= 1'b0;
               ts_q[e]   <= st_ts;
            end else if (lk_hit[e]) begin
               lock_q[e] <= (lk_op == LK_ACQUIRE);
            end
         end
      end
   end

   assign rd_locked = lock_q[rd_idx];
   assign rd_ts     = ts_q[rd_idx];
   assign lk_locked = lock_q[lk_idx];
endmodule

// File: rtl/vlock_validator.sv
module vlock_validator #(
   parameter int AW     = 32,
   parameter int DEPTH  = 256,
   parameter int TSW    = 16,
   parameter int NWR    = 2,
   parameter int NUM_TX = 4,
   localparam int IW    = $clog2(DEPTH),
   localparam int TXW   = (NUM_TX > 1) ? $clog2(NUM_TX) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_valid,
   input  logic [TXW-1:0]    start_tx,
   input  logic              rd_valid,
   input  logic [TXW-1:0]    rd_tx,
   input  logic [AW-1:0]     rd_addr,
   output logic              rd_resp_valid,
   output logic              rd_ok,
   input  logic              lk_valid,
   input  logic              lk_acquire,
   input  logic [AW-1:0]     lk_addr,
   output logic              lk_resp_valid,
   output logic              lk_busy,
   input  logic              cm_valid,
   input  logic              cm_update,
   input  logic [NWR-1:0]    cm_wr_en,
   input  logic [NWR*AW-1:0] cm_wr_addr,
   output logic [TSW-1:0]    gclk
);
   if ((DEPTH < 2) || ((DEPTH & (DEPTH - 1)) != 0)) begin : g_bad_depth
      $error("DEPTH must be a power of two of at least 2");
   end
   if (AW <= IW) begin : g_bad_aw
      $error("AW must exceed log2(DEPTH)");
   end
   if (TSW < 2) begin : g_bad_tsw
      $error("TSW must be at least 2");
   end
   if ((NWR < 1) || (NUM_TX < 1)) begin : g_bad_cnt
      $error("NWR and NUM_TX must be at least 1");
   end

   // hash: low-order word-address bits
   logic [IW-1:0]     rd_idx, lk_idx;
   logic [NWR*IW-1:0] st_idx;
   logic              unused_rd_hi, unused_lk_hi;
   logic [NWR-1:0]    unused_wr_hi;

   assign rd_idx       = rd_addr[IW-1:0];
   assign lk_idx       = lk_addr[IW-1:0];
   assign unused_rd_hi = ^rd_addr[AW-1:IW];
   assign unused_lk_hi = ^lk_addr[AW-1:IW];

   for (genvar k = 0; k < NWR; k++) begin : g_wport
      assign st_idx[k*IW +: IW] = cm_wr_addr[k*AW +: IW];
      assign unused_wr_hi[k]    = ^cm_wr_addr[k*AW+IW +: AW-IW];
   end

   logic           bump;
   logic [TSW-1:0] gclk_next;
   logic [NWR-1:0] st_en;

   assign bump  = cm_valid && cm_update;
   assign st_en = cm_wr_en & {NWR{bump}};

   vlock_clock #(.TSW(TSW)) u_clock (
      .clk      (clk),
      .rst_n    (rst_n),
      .bump     (bump),
      .gclk_q   (gclk),
      .gclk_next(gclk_next)
   );

   logic [TSW-1:0] rd_start;

   vlock_start #(.TSW(TSW), .NUM_TX(NUM_TX)) u_start (
      .clk     (clk),
      .rst_n   (rst_n),
      .st_valid(start_valid),
      .st_tx   (start_tx),
      .gclk    (gclk),
      .rd_tx   (rd_tx),
      .rd_start(rd_start)
   );

   logic           rd_locked, lk_locked;
   logic [TSW-1:0] rd_ts;

   vlock_table #(.DEPTH(DEPTH), .TSW(TSW), .NWR(NWR)) u_table (
      .clk       (clk),
      .rst_n     (rst_n),
      .rd_idx    (rd_idx),
      .rd_locked (rd_locked),
      .rd_ts     (rd_ts),
      .lk_valid  (lk_valid),
      .lk_acquire(lk_acquire),
      .lk_idx    (lk_idx),
      .lk_locked (lk_locked),
      .st_en     (st_en),
      .st_idx    (st_idx),
      .st_ts     (gclk_next)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rd_resp_valid <= 1'b0;
         rd_ok         <= 1'b0;
         lk_resp_valid <= 1'b0;
         lk_busy       <= 1'b0;
      end else begin
         rd_resp_valid <= rd_valid;
         rd_ok         <= rd_valid && !rd_locked && (rd_ts <= rd_start);
         lk_resp_valid <= lk_valid;
         lk_busy       <= lk_valid && lk_acquire && lk_locked;
      end
   end
endmodule

// File: rtl/vlock_checker.sv
module vlock_checker #(
   parameter int TSW = 16
) (
   input logic           clk,
   input logic           rst_n,
   input logic           cm_valid,
   input logic           cm_update,
   input logic [TSW-1:0] gclk,
   input logic           rd_valid,
   input logic           rd_resp_valid,
   input logic           rd_ok,
   input logic           lk_valid,
   input logic           lk_resp_valid,
   input logic           lk_busy
);
   p_clk_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (cm_valid && cm_update) |=> (gclk == TSW'($past(gclk) + TSW'(1))));

   p_clk_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !(cm_valid && cm_update) |=> $stable(gclk));

   p_rd_resp_r4: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid |=> rd_resp_valid);

   p_ok_gated_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_resp_valid |-> !rd_ok);

   p_lk_resp_r7: assert property (@(posedge clk) disable iff (!rst_n)
      lk_valid |=> lk_resp_valid);

   p_busy_gated_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !lk_resp_valid |-> !lk_busy);
endmodule

bind vlock_validator vlock_checker #(.TSW(TSW)) u_vlock_checker (
   .clk          (clk),
   .rst_n        (rst_n),
   .cm_valid     (cm_valid),
   .cm_update    (cm_update),
   .gclk         (gclk),
   .rd_valid     (rd_valid),
   .rd_resp_valid(rd_resp_valid),
   .rd_ok        (rd_ok),
   .lk_valid     (lk_valid),
   .lk_resp_valid(lk_resp_valid),
   .lk_busy      (lk_busy)
);

// File: tb/vlock_validator_test.sv
`timescale 1ns/1ps
module vlock_validator_test;
   localparam int AW = 16, DEPTH = 16, TSW = 8, NWR = 2, NUM_TX = 4, TXW = 2;

   logic clk = 1'b0, rst_n = 1'b0;
   logic start_valid = 0; logic [TXW-1:0] start_tx = 0;
   logic rd_valid = 0; logic [TXW-1:0] rd_tx = 0; logic [AW-1:0] rd_addr = 0;
   logic rd_resp_valid, rd_ok;
   logic lk_valid = 0, lk_acquire = 0; logic [AW-1:0] lk_addr = 0;
   logic lk_resp_valid, lk_busy;
   logic cm_valid = 0, cm_update = 0; logic [NWR-1:0] cm_wr_en = 0;
   logic [NWR*AW-1:0] cm_wr_addr = 0;
   logic [TSW-1:0] gclk;

   always #10 clk = ~clk;  // 50 MHz

   vlock_validator #(.AW(AW), .DEPTH(DEPTH), .TSW(TSW), .NWR(NWR), .NUM_TX(NUM_TX)) uut (
      .clk(clk), .rst_n(rst_n),
      .start_valid(start_valid), .start_tx(start_tx),
      .rd_valid(rd_valid), .rd_tx(rd_tx), .rd_addr(rd_addr),
      .rd_resp_valid(rd_resp_valid), .rd_ok(rd_ok),
      .lk_valid(lk_valid), .lk_acquire(lk_acquire), .lk_addr(lk_addr),
      .lk_resp_valid(lk_resp_valid), .lk_busy(lk_busy),
      .cm_valid(cm_valid), .cm_update(cm_update), .cm_wr_en(cm_wr_en),
      .cm_wr_addr(cm_wr_addr), .gclk(gclk)
   );

   typedef struct { string tag; logic val; } exp_t;
   exp_t rdq[$];
   exp_t lkq[$];

   int checks = 0, errors = 0;
   bit done = 0;

   // bench reference state, built from the requirements
   int  m_clk = 0;
   int  m_ts [DEPTH];
   bit  m_lk [DEPTH];
   int  m_st [NUM_TX];

   task automatic chk(string tag, int act, int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   // driver: one cycle of stimulus, pushes expected responses
   task automatic op(string tag, bit st = 0, int st_t = 0,
                     bit rd = 0, int rd_t = 0, int rd_a = 0,
                     bit lk = 0, bit acq = 0, int lk_a = 0,
                     bit cm = 0, bit up = 0, bit [1:0] we = 0, int wa0 = 0, int wa1 = 0);
      int ri, li;
      ri = rd_a % DEPTH; li = lk_a % DEPTH;
      start_valid = st; start_tx = TXW'(st_t);
      rd_valid = rd; rd_tx = TXW'(rd_t); rd_addr = AW'(rd_a);
      lk_valid = lk; lk_acquire = acq; lk_addr = AW'(lk_a);
      cm_valid = cm; cm_update = up; cm_wr_en = we;
      cm_wr_addr = {AW'(wa1), AW'(wa0)};
      if (rd) rdq.push_back('{tag, !m_lk[ri] && (m_ts[ri] <= m_st[rd_t])});
      if (lk) lkq.push_back('{tag, acq && m_lk[li]});
      if (lk && !(acq && m_lk[li])) m_lk[li] = acq;
      if (st) m_st[st_t] = m_clk;
      if (cm && up) begin
         m_clk++;
         if (we[0]) begin m_ts[wa0 % DEPTH] = m_clk; m_lk[wa0 % DEPTH] = 0; end
         if (we[1]) begin m_ts[wa1 % DEPTH] = m_clk; m_lk[wa1 % DEPTH] = 0; end
      end
      @(posedge clk);
      @(negedge clk);
      start_valid = 0; rd_valid = 0; lk_valid = 0; cm_valid = 0; cm_wr_en = 0;
      chk({tag, " R2 gclk"}, int'(gclk), m_clk);
   endtask

   // monitor: compares responses against the queued expectations
   always @(negedge clk) begin
      if (rst_n && !done) begin
         if (rd_resp_valid) begin
            if (rdq.size() == 0) chk("R4 unexpected read response", 1, 0);
            else begin
               automatic exp_t e = rdq.pop_front();
               chk({e.tag, " rd_ok"}, int'(rd_ok), int'(e.val));
            end
         end
         if (lk_resp_valid) begin
            if (lkq.size() == 0) chk("R7 unexpected lock response", 1, 0);
            else begin
               automatic exp_t e = lkq.pop_front();
               chk({e.tag, " lk_busy"}, int'(lk_busy), int'(e.val));
            end
         end
      end
   end

   task automatic finish_run();
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   endtask

   initial begin
      #(20 * 200000);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      foreach (m_ts[i]) begin m_ts[i] = 0; m_lk[i] = 0; end
      foreach (m_st[i]) m_st[i] = 0;
      repeat (3) @(negedge clk);
      rst_n = 1;
      // R1 reset state
      chk("R1 gclk", int'(gclk), 0);
      chk("R1 rd_resp_valid", int'(rd_resp_valid), 0);
      chk("R1 lk_resp_valid", int'(lk_resp_valid), 0);
      op(.tag("R1 read fresh entry"), .rd(1), .rd_t(0), .rd_a(5));
      // R3 / R6 / R4
      op(.tag("R3 start tx0"), .st(1), .st_t(0));
      op(.tag("R6 commit addr5"), .cm(1), .up(1), .we(2'b01), .wa0(5));
      op(.tag("R4 newer stamp fails"), .rd(1), .rd_t(0), .rd_a(5));
      op(.tag("R3 start tx1"), .st(1), .st_t(1));
      op(.tag("R4 equal stamp passes"), .rd(1), .rd_t(1), .rd_a(5));
      // R7 / R9 / R8
      op(.tag("R7 acquire free"), .lk(1), .acq(1), .lk_a(5));
      op(.tag("R7 acquire held"), .lk(1), .acq(1), .lk_a(5));
      op(.tag("R4 locked fails"), .rd(1), .rd_t(1), .rd_a(5));
      op(.tag("R9 alias sees lock"), .rd(1), .rd_t(1), .rd_a(5 + DEPTH));
      op(.tag("R9 alias acquire busy"), .lk(1), .acq(1), .lk_a(5 + 3 * DEPTH));
      op(.tag("R8 release"), .lk(1), .acq(0), .lk_a(5));
      op(.tag("R8 stamp kept after release"), .rd(1), .rd_t(1), .rd_a(5));
      op(.tag("R8 stamp kept, older start"), .rd(1), .rd_t(0), .rd_a(5));
      // R10 / R2 read-only commit
      op(.tag("R10 read-only commit"), .cm(1), .up(0), .we(2'b11), .wa0(7), .wa1(8));
      op(.tag("R10 addr7 untouched"), .rd(1), .rd_t(0), .rd_a(7));
      op(.tag("R10 addr8 untouched"), .rd(1), .rd_t(0), .rd_a(8));
      // R5 read in commit cycle sees old entry
      op(.tag("R5 read during commit"), .rd(1), .rd_t(1), .rd_a(5),
         .cm(1), .up(1), .we(2'b01), .wa0(5));
      op(.tag("R5 read after commit"), .rd(1), .rd_t(1), .rd_a(5));
      // R3 start in commit cycle takes old value
      op(.tag("R3 start during commit"), .st(1), .st_t(2),
         .cm(1), .up(1), .we(2'b01), .wa0(11));
      op(.tag("R3 old start rejects"), .rd(1), .rd_t(2), .rd_a(11));
      // R6 two-port stamp, clears a held lock, wins over same-cycle lock
      op(.tag("R6 lock addr9"), .lk(1), .acq(1), .lk_a(9));
      op(.tag("R6 two-word commit"), .lk(1), .acq(1), .lk_a(10),
         .cm(1), .up(1), .we(2'b11), .wa0(9), .wa1(10));
      op(.tag("R3 start tx3"), .st(1), .st_t(3));
      op(.tag("R6 addr9 unlocked stamped"), .rd(1), .rd_t(3), .rd_a(9));
      op(.tag("R6 addr10 stamped"), .rd(1), .rd_t(3), .rd_a(10));
      op(.tag("R6 addr9 too new for tx2"), .rd(1), .rd_t(2), .rd_a(9));
      op(.tag("R6 addr10 free again"), .lk(1), .acq(1), .lk_a(10));
      // R9 alias commit
      op(.tag("R9 commit via alias"), .cm(1), .up(1), .we(2'b10), .wa1(3 + 2 * DEPTH));
      op(.tag("R9 alias stamp seen"), .rd(1), .rd_t(3), .rd_a(3));
      // R2 run of commits
      for (int n = 0; n < 6; n++)
         op(.tag("R2 commit run"), .cm(1), .up(n % 2 == 0), .we(2'b01), .wa0(n));
      op(.tag("R4 idle"));
      chk("R4 read queue drained", rdq.size(), 0);
      chk("R7 lock queue drained", lkq.size(), 0);
      finish_run();
   end
endmodule